// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor

This block is a tiny processor whose whole instruction set is one operation: take two words from memory, subtract one from the other, write the difference back, and jump when the difference is zero or below. Code and data share one word-addressed memory. Every instruction is three adjacent words that hold three addresses. The first is the subtrahend location. The second is the minuend location, which also receives the result. The third is the branch target.

The core runs from address 0 after reset. It uses one synchronous single-port memory and makes exactly one access per cycle, so each instruction takes six cycles. A negative address stops the machine, and so does a taken jump to a negative target. The core then asserts `halted` and stays frozen until the next reset. An external load port shares the memory with the core. It can write a program image and read words back while reset is held or once the core has halted.

The controller moves through the states FETCH_A → FETCH_B → FETCH_C → READ_A → READ_B → WRITE, then returns to FETCH_A. READ_A exits to HALT on a negative operand address. WRITE exits to HALT on a taken branch to a negative target. HALT only leaves through reset.

Top module: `subleq_core`

## Requirements
- R1: While `rst_n` is low, the core sets `pc` to 0 and `halted` to 0. Memory contents are kept, and the first instruction after reset is fetched from address 0.
- R2: The three words at `pc`, `pc+1` and `pc+2` (modulo 256) are taken as the operand addresses a, b and c.
- R3: The core writes the 16-bit two's complement difference Mem[b] − Mem[a] into Mem[b]. The difference wraps modulo 2^16, so 0x8000 − 1 gives 0x7FFF.
- R4: When the stored difference is ≤ 0 (bit 15 set, or all zero), the branch is taken and `pc` becomes c. Otherwise `pc` becomes `pc+3` modulo 256.
- R5: If a or b is negative (bit 15 set), the core halts without writing memory, and `pc` keeps the address of that instruction.
- R6: A taken branch to a negative c halts the core, and `pc` keeps the address of that instruction. A negative c on a branch that is not taken has no effect, and execution continues at `pc+3`.
- R7: Once halted, `halted` stays 1, `pc` stays stable and the core writes nothing until `rst_n` goes low.
- R8: An instruction takes exactly six cycles. From reset release, n completed instructions that end in a branch halt give `halted` = 1 after 6·n clock edges. A halt on a negative operand in instruction n gives `halted` = 1 after 6·(n−1)+4 edges. `pc` changes only at the end of the WRITE state.
- R9: The load port has control of the memory only while `rst_n` is low or `halted` is 1. A write with `ld_we` high stores `ld_wdata` at `ld_addr`. `ld_rdata` shows the word at `ld_addr` one clock later. A port write made while the core is running has no effect.
- R10: A non-negative operand word addresses memory through its low 8 bits, so 316 selects word 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | 8 | Load-port word address |
| ld_wdata | input | 16 | Load-port write data |
| ld_rdata | output | 16 | Memory read data, one cycle after the address |
| halted | output | 1 | Core stopped; held until reset |
| pc | output | 8 | Address of the current instruction |

## Verification
The bound checker watches every cycle for the following. `halted` must be sticky, and `pc` must be frozen while halted. `pc` may move only on the edge that leaves WRITE, and then only to c or to `pc+3`. Memory writes by the core must follow READ_B and never happen while halted. The arithmetic result, the wrap at the 16-bit boundary, the 8-bit address aliasing, the exact halt timing for each halt cause and the blocking of the load port during a run all depend on memory contents. Only the directed scenarios show these, by reading the memory back after the halt.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    localparam int SL_WORD_W = 16;
    localparam int SL_ADDR_W = 8;

    typedef enum logic [2:0] {
        S_FETCH_A = 3'd0,
        S_FETCH_B = 3'd1,
        S_FETCH_C = 3'd2,
        S_READ_A  = 3'd3,
        S_READ_B  = 3'd4,
        S_WRITE   = 3'd5,
        S_HALT    = 3'd6
    } sl_state_t;

endpackage

// File: rtl/subleq_mem.sv
module subleq_mem #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    // read-before-write, registered output
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end

endmodule

// File: rtl/subleq_alu.sv
module subleq_alu #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic [WORD_W-1:0] rd_word,
    input  logic [WORD_W-1:0] subtrahend,
    output logic [WORD_W-1:0] diff,
    output logic              diff_le0,
    output logic              rd_neg,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [WORD_W-ADDR_W-2:0] mid_bits;

    always_comb begin
        diff     = rd_word - subtrahend;
        diff_le0 = diff[WORD_W-1] | (diff == '0);
        rd_neg   = rd_word[WORD_W-1];
        rd_addr  = rd_word[ADDR_W-1:0];
        mid_bits = rd_word[WORD_W-2:ADDR_W];
    end

    // middle bits of an operand word do not take part in addressing
    logic mid_unused;
    assign mid_unused = ^mid_bits;

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
    import subleq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              rd_neg,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] diff,
    input  logic              diff_le0,
    output logic [ADDR_W-1:0] core_addr,
    output logic              core_we,
    output logic [WORD_W-1:0] core_wdata,
    output logic [WORD_W-1:0] sub_val,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] c_addr_o,
    output logic              halted_o,
    output sl_state_t         state_o
);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3);

    sl_state_t         state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] a_addr_q, b_addr_q, c_addr_q;
    logic              a_neg_q, b_neg_q, c_neg_q;
    logic [WORD_W-1:0] va_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH_A;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH_A: state_d = S_FETCH_B;
            S_FETCH_B: state_d = S_FETCH_C;
            S_FETCH_C: state_d = S_READ_A;
            S_READ_A:  state_d = (a_neg_q | b_neg_q) ? S_HALT : S_READ_B;
            S_READ_B:  state_d = S_WRITE;
            S_WRITE:   state_d = (diff_le0 & c_neg_q) ? S_HALT : S_FETCH_A;
            S_HALT:    state_d = S_HALT;
            default:   state_d = S_HALT;
        endcase
    end

    // outputs per state
    always_comb begin
        core_addr  = pc_q;
        core_we    = 1'b0;
        core_wdata = diff;
        unique case (state_q)
            S_FETCH_A: core_addr = pc_q;
            S_FETCH_B: core_addr = pc_q + STEP1;
            S_FETCH_C: core_addr = pc_q + STEP2;
            S_READ_A:  core_addr = a_addr_q;
            S_READ_B:  core_addr = b_addr_q;
            S_WRITE: begin
                core_addr = b_addr_q;
                core_we   = 1'b1;
            end
            S_HALT:    core_addr = pc_q;
            default:   core_addr = pc_q;
        endcase
    end

    // operand and program-counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            a_addr_q <= '0;
            b_addr_q <= '0;
            c_addr_q <= '0;
            a_neg_q  <= 1'b0;
            b_neg_q  <= 1'b0;
            c_neg_q  <= 1'b0;
            va_q     <= '0;
        end else begin
            unique case (state_q)
                S_FETCH_B: begin
                    a_neg_q  <= rd_neg;
                    a_addr_q <= rd_addr;
                end
                S_FETCH_C: begin
                    b_neg_q  <= rd_neg;
                    b_addr_q <= rd_addr;
                end
                S_READ_A: begin
                    c_neg_q  <= rd_neg;
                    c_addr_q <= rd_addr;
                end
                S_READ_B: va_q <= rd_word;
                S_WRITE: begin
                    if (!diff_le0) begin
                        pc_q <= pc_q + STEP3;
                    end else if (!c_neg_q) begin
                        pc_q <= c_addr_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sub_val  = va_q;
    assign pc_o     = pc_q;
    assign c_addr_o = c_addr_q;
    assign halted_o = (state_q == S_HALT);
    assign state_o  = state_q;

endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
#(
    parameter int WORD_W = SL_WORD_W,
    parameter int ADDR_W = SL_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_wdata,
    output logic [WORD_W-1:0] ld_rdata,
    output logic              halted,
    output logic [ADDR_W-1:0] pc
);
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] diff, sub_val, core_wdata;
    logic              diff_le0, rd_neg, core_we;
    logic [ADDR_W-1:0] rd_addr, core_addr, opc_addr;
    sl_state_t         state_w;

    logic              port_sel;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;

    // port owns the memory in reset or after halt
    always_comb begin
        port_sel  = !rst_n || halted;
        mem_we    = port_sel ? ld_we    : core_we;
        mem_addr  = port_sel ? ld_addr  : core_addr;
        mem_wdata = port_sel ? ld_wdata : core_wdata;
    end

    subleq_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rd_word)
    );

    subleq_alu #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_alu (
        .rd_word    (rd_word),
        .subtrahend (sub_val),
        .diff       (diff),
        .diff_le0   (diff_le0),
        .rd_neg     (rd_neg),
        .rd_addr    (rd_addr)
    );

    subleq_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_word    (rd_word),
        .rd_neg     (rd_neg),
        .rd_addr    (rd_addr),
        .diff       (diff),
        .diff_le0   (diff_le0),
        .core_addr  (core_addr),
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .sub_val    (sub_val),
        .pc_o       (pc),
        .c_addr_o   (opc_addr),
        .halted_o   (halted),
        .state_o    (state_w)
    );

    assign ld_rdata = rd_word;

endmodule

// File: rtl/subleq_core_chk.sv
module subleq_core_chk
    import subleq_pkg::*;
#(
    parameter int ADDR_W = SL_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input sl_state_t         state,
    input logic [ADDR_W-1:0] pc,
    input logic              halted,
    input logic              core_we,
    input logic [ADDR_W-1:0] c_addr
);
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0) && !halted); // R1

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R7

    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R7

    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !core_we); // R7

    AST_PC_MOVES_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != $past(pc)) |-> ($past(state) == S_WRITE)); // R8

    AST_WRITE_FOLLOWS_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> ($past(state) == S_READ_B)); // R8

    AST_NEXT_PC_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == S_WRITE) && (state == S_FETCH_A)) |->
        ((pc == ADDR_W'($past(pc) + ADDR_W'(3))) || (pc == $past(c_addr)))); // R4

endmodule

bind subleq_core subleq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_w),
    .pc      (pc),
    .halted  (halted),
    .core_we (core_we),
    .c_addr  (opc_addr)
);

// File: tb/tb_subleq_core.sv
`timescale 1ns/1ps
module tb_subleq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_wdata = '0;
    logic [15:0] ld_rdata;
    logic        halted;
    logic [7:0]  pc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    subleq_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_wdata (ld_wdata),
        .ld_rdata (ld_rdata),
        .halted   (halted),
        .pc       (pc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_wdata = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic get(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        ld_addr = a;
        @(negedge clk);
        d = ld_rdata;
    endtask

    task automatic begin_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_wdata = '0;
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic instr(input logic [7:0] at, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        put(at, a);
        put(at + 8'd1, b);
        put(at + 8'd2, c);
    endtask

    // release reset at a falling edge, count rising edges until halted
    task automatic run(input int poke_at, output int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        for (int k = 0; k < 5000; k++) begin
            if (poke_at != 0 && cycles == poke_at) begin
                ld_we = 1'b1; ld_addr = 8'd80; ld_wdata = 16'h1234;
            end else begin
                ld_we = 1'b0;
            end
            @(negedge clk);
            cycles++;
            if (halted) break;
        end
        ld_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        begin_reset();
        put(8'd5, 16'hBEEF);
        repeat (2) @(negedge clk);
        check("R1 halted in reset", {15'd0, halted}, 16'd0);
        check("R1 pc in reset", {8'd0, pc}, 16'd0);
        get(8'd5, d);
        check("R9 port read in reset", d, 16'hBEEF);
    endtask

    task automatic t_basic();
        int cyc; logic [15:0] d;
        begin_reset();
        instr(8'd0, 16'd20, 16'd21, 16'hFFFF);
        instr(8'd3, 16'd22, 16'd22, 16'hFFFF);
        put(8'd20, 16'd3); put(8'd21, 16'd7); put(8'd22, 16'd5);
        run(0, cyc);
        check("R8 cycles two instrs", 16'(cyc), 16'd12);
        check("R6 halted on neg target", {15'd0, halted}, 16'd1);
        check("R4 R6 pc advanced by 3 past untaken neg c", {8'd0, pc}, 16'd3);
        get(8'd21, d); check("R3 7-3", d, 16'd4);
        get(8'd22, d); check("R3 self subtract", d, 16'd0);
        get(8'd20, d); check("R2 a unchanged", d, 16'd3);
    endtask

    task automatic t_branch();
        int cyc; logic [15:0] d;
        begin_reset();
        instr(8'd0, 16'd30, 16'd31, 16'd9);
        instr(8'd9, 16'd32, 16'd32, 16'hFFFE);
        put(8'd30, 16'd10); put(8'd31, 16'd4);
        run(0, cyc);
        check("R4 taken branch cycles", 16'(cyc), 16'd12);
        check("R4 pc took c", {8'd0, pc}, 16'd9);
        get(8'd31, d); check("R3 negative result", d, 16'hFFFA);
    endtask

    task automatic t_neg_operand();
        int cyc; logic [15:0] d;
        begin_reset();
        instr(8'd0, 16'hFFFB, 16'd40, 16'd0);
        put(8'd40, 16'd7);
        run(0, cyc);
        check("R5 R8 neg a halt cycles", 16'(cyc), 16'd4);
        check("R5 pc held", {8'd0, pc}, 16'd0);
        get(8'd40, d); check("R5 b untouched", d, 16'd7);

        begin_reset();
        instr(8'd0, 16'd40, 16'd40, 16'd3);
        instr(8'd3, 16'd40, 16'hFFFF, 16'd0);
        put(8'd40, 16'd7); put(8'd255, 16'd9);
        run(0, cyc);
        check("R5 R8 neg b halt in second instr", 16'(cyc), 16'd10);
        check("R5 pc at faulting instr", {8'd0, pc}, 16'd3);
        get(8'd255, d); check("R5 no write via low bits", d, 16'd9);
    endtask

    task automatic t_wrap_alias();
        int cyc; logic [15:0] d;
        begin_reset();
        instr(8'd0, 16'd50, 16'd51, 16'hFFFF);
        instr(8'd3, 16'd316, 16'd61, 16'hFFFF);
        instr(8'd6, 16'd52, 16'd52, 16'hFFFF);
        put(8'd50, 16'd1); put(8'd51, 16'h8000);
        put(8'd60, 16'd2); put(8'd61, 16'd9);
        run(0, cyc);
        check("R8 three instrs", 16'(cyc), 16'd18);
        get(8'd51, d); check("R3 wrap 0x8000-1", d, 16'h7FFF);
        get(8'd61, d); check("R10 alias 316->60", d, 16'd7);
    endtask

    task automatic t_loop_hold();
        int cyc; logic [15:0] d; logic [7:0] pc_seen;
        begin_reset();
        instr(8'd0, 16'd70, 16'd71, 16'd6);
        instr(8'd3, 16'd72, 16'd72, 16'd0);
        instr(8'd6, 16'd72, 16'd72, 16'hFFFF);
        put(8'd70, 16'd1); put(8'd71, 16'd3); put(8'd80, 16'h0055);
        run(5, cyc);
        check("R8 loop length", 16'(cyc), 16'd36);
        check("R4 loop exit pc", {8'd0, pc}, 16'd6);
        get(8'd71, d); check("R3 counter reached 0", d, 16'd0);
        get(8'd80, d); check("R9 port write ignored while running", d, 16'h0055);
        pc_seen = pc;
        repeat (10) @(negedge clk);
        check("R7 still halted", {15'd0, halted}, 16'd1);
        check("R7 pc frozen", {8'd0, pc}, {8'd0, pc_seen});
        get(8'd72, d); check("R7 no write after halt", d, 16'd0);
        put(8'd80, 16'h0077);
        get(8'd80, d); check("R9 port write when halted", d, 16'h0077);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset clears halt", {15'd0, halted}, 16'd0);
        check("R1 reset pc", {8'd0, pc}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_branch();
        t_neg_operand();
        t_wrap_alias();
        t_loop_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule